// File: doc/BRIEF.md
# Multi-Input Edge Timestamp Capture Unit

This block records the current precision time whenever a watched edge occurs on a set of external pins. Eight edge monitors, numbered 0 to 7, can each be attached to one of twelve pins or left unattached. Each monitor can be armed for rising edges, falling edges or both. A monitor can also be set to stop after it has captured once. Each pin passes through a two-flop synchronizer and an edge-detect stage before its time is stored. The stored time therefore trails the pin by a fixed number of clocks, and software removes that latency afterwards.

Captures are held in a small in-order queue. All monitors that detect an edge in the same clock cycle share one queued record. A record with more than one monitor carries a packed per-monitor word that shows which monitors fired and in which direction. Status outputs describe the record at the head of the queue. Software takes its contents from a sequential read port. When the queue is full, a new capture is dropped and a saturating lost-capture count goes up by one. Software keeps reading records until the pending flag clears.

Top module: `evt_stamp_unit`

## Requirements
- R1: After reset, evt_pending is 0, evt_missed is 0 and rd_data is 0.
- R2: Configuration takes two writes. A pulse on sel_wr makes sel_mon the current monitor, gives it pin sel_pin and disarms it: its edge enables and single-capture flag clear and its stopped state clears. A later pulse on mode_wr loads mode_rise, mode_fall and mode_single into the current monitor. A pin value of 0, or any value above 12, leaves the monitor unattached, and it never detects.
- R3: Pin number k (1 to 12) is bit k-1 of pins_in. A monitor detects a low-to-high change only when rising is enabled, and a high-to-low change only when falling is enabled.
- R4: A pin change that the clock first samples at edge n is stored at edge n+2. The stored time is the value on now_sec/now_ns in the clock cycle just before edge n+2.
- R5: When the head record comes from exactly one monitor, evt_pending=1, evt_multi=0, evt_num gives that monitor's number, and evt_rise is 1 for a rising edge and 0 for a falling edge.
- R6: For a single-monitor record, the words on rd_data come in this order, and each rd_strobe moves to the next: now_ns[15:0], {2'b00, now_ns[29:16]}, now_sec[15:0], now_sec[31:16]. The strobe on the last word removes the record.
- R7: All monitors that detect in the same cycle share one record, with evt_multi=1. Its first data word holds bit 2i = monitor i detected and bit 2i+1 = monitor i rising, so monitor 7 uses bits 15:14. The four time words follow.
- R8: Up to 4 records are held, and they are read out in the order they were captured.
- R9: A detection cycle that finds the queue full, with no record removed in that cycle, is dropped and increments evt_missed. evt_missed saturates at 7 and returns to 0 when a record is removed.
- R10: A monitor in single-capture mode stops detecting after its first detection, and stays stopped until sel_wr selects it again.
- R11: rd_strobe while no record is pending has no effect. rd_data reads 0, and the next record still begins at its first word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pins_in | input | 12 | Asynchronous watched pins; bit k-1 is pin k |
| now_sec | input | 32 | Current time, seconds |
| now_ns | input | 30 | Current time, nanoseconds |
| sel_wr | input | 1 | First configuration write strobe |
| sel_mon | input | 3 | Monitor number for sel_wr |
| sel_pin | input | 4 | Pin for the monitor (0 = none) |
| mode_wr | input | 1 | Second configuration write strobe |
| mode_rise | input | 1 | Enable rising-edge detection |
| mode_fall | input | 1 | Enable falling-edge detection |
| mode_single | input | 1 | Stop after the first capture |
| evt_pending | output | 1 | A record is waiting |
| evt_multi | output | 1 | Head record covers several monitors |
| evt_num | output | 3 | Monitor of a single-monitor head record |
| evt_rise | output | 1 | Direction of that monitor's edge |
| evt_missed | output | 3 | Saturating lost-capture count |
| rd_strobe | input | 1 | Advance the data port by one word |
| rd_data | output | 16 | Current data word of the head record |

## Verification
The hardest state to reach from the ports is a lost-capture count at saturation while records are still queued. To reach it, one monitor watches both edges of one pin. The bench toggles that pin every other cycle and reads nothing, so four records fill the queue and nine more edges arrive. It then checks that removing one record clears the count and leaves the oldest remaining record at the head. For the shared record, one pin feeds two monitors at opposite ends of the monitor range, which guarantees that both detect in the same cycle.

// File: rtl/evt_stamp_unit.sv
module evt_stamp_unit #(
  parameter int DEPTH = 4,
  parameter int NPIN  = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NPIN-1:0]      pins_in,
  input  logic [31:0]          now_sec,
  input  logic [29:0]          now_ns,
  input  logic                 sel_wr,
  input  logic [2:0]           sel_mon,
  input  logic [3:0]           sel_pin,
  input  logic                 mode_wr,
  input  logic                 mode_rise,
  input  logic                 mode_fall,
  input  logic                 mode_single,
  output logic                 evt_pending,
  output logic                 evt_multi,
  output logic [2:0]           evt_num,
  output logic                 evt_rise,
  output logic [2:0]           evt_missed,
  input  logic                 rd_strobe,
  output logic [15:0]          rd_data
);
  localparam int NMON = 8;
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0]   FULLC = (AW+1)'(DEPTH);
  localparam logic [AW-1:0] LASTP = AW'(DEPTH - 1);
  localparam logic [3:0]    NPINC = 4'(NPIN);

  logic [NPIN-1:0] sync1, sync2, sync3;
  logic [3:0]      pin_sel [NMON];
  logic [NMON-1:0] en_r, en_f, one_shot, done;
  logic [2:0]      cur_mon;
  logic [NMON-1:0] det_v, rise_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      sync3 <= '0;
    end else begin
      sync1 <= pins_in;
      sync2 <= sync1;
      sync3 <= sync2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NMON; i++) pin_sel[i] <= '0;
      en_r     <= '0;
      en_f     <= '0;
      one_shot <= '0;
      done     <= '0;
      cur_mon  <= '0;
    end else begin
      done <= done | (det_v & one_shot);
      if (mode_wr) begin
        en_r[cur_mon]     <= mode_rise;
        en_f[cur_mon]     <= mode_fall;
        one_shot[cur_mon] <= mode_single;
      end
      if (sel_wr) begin
        cur_mon           <= sel_mon;
        pin_sel[sel_mon]  <= sel_pin;
        en_r[sel_mon]     <= 1'b0;
        en_f[sel_mon]     <= 1'b0;
        one_shot[sel_mon] <= 1'b0;
        done[sel_mon]     <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < NMON; g++) begin : g_mon
    logic       hooked, cur, old;
    logic [3:0] idx;
    assign hooked = (pin_sel[g] != 4'd0) && (pin_sel[g] <= NPINC);
    assign idx    = hooked ? pin_sel[g] - 4'd1 : 4'd0;
    assign cur    = hooked & sync2[idx];
    assign old    = hooked & sync3[idx];
    assign rise_v[g] = cur & ~old & en_r[g] & ~done[g];
    assign det_v[g]  = rise_v[g] | (~cur & old & en_f[g] & ~done[g]);

    assert_single_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (det_v[g] && one_shot[g]) |=> !det_v[g]);
  end

  logic [NMON-1:0] q_det  [DEPTH];
  logic [NMON-1:0] q_rise [DEPTH];
  logic [31:0]     q_sec  [DEPTH];
  logic [29:0]     q_ns   [DEPTH];
  logic [AW-1:0]   wptr, rptr;
  logic [AW:0]     count;
  logic [2:0]      rd_idx, phase;
  logic            any_det, full, pop_w, push;
  logic [NMON-1:0] hd_det, hd_rise;
  logic [15:0]     ext_word;

  assign any_det = |det_v;
  assign full    = (count == FULLC);
  assign pop_w   = rd_strobe && evt_pending && (phase == 3'd4);
  assign push    = any_det && (!full || pop_w);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr       <= '0;
      rptr       <= '0;
      count      <= '0;
      rd_idx     <= '0;
      evt_missed <= '0;
    end else begin
      if (push) begin
        q_det[wptr]  <= det_v;
        q_rise[wptr] <= rise_v;
        q_sec[wptr]  <= now_sec;
        q_ns[wptr]   <= now_ns;
        wptr <= (wptr == LASTP) ? '0 : wptr + 1'b1;
      end
      if (pop_w) rptr <= (rptr == LASTP) ? '0 : rptr + 1'b1;
      if (push && !pop_w)      count <= count + 1'b1;
      else if (!push && pop_w) count <= count - 1'b1;
      if (pop_w)                        rd_idx <= '0;
      else if (rd_strobe && evt_pending) rd_idx <= rd_idx + 3'd1;
      if (pop_w)                                        evt_missed <= '0;
      else if (any_det && full && evt_missed != 3'd7)   evt_missed <= evt_missed + 3'd1;
    end
  end

  assign hd_det      = q_det[rptr];
  assign hd_rise     = q_rise[rptr];
  assign evt_pending = (count != '0);
  assign evt_multi   = evt_pending && ((hd_det & (hd_det - 1'b1)) != '0);
  assign phase       = evt_multi ? rd_idx : rd_idx + 3'd1;

  always_comb begin
    evt_num = '0;
    for (int i = NMON - 1; i >= 0; i--)
      if (hd_det[i]) evt_num = 3'(i);
    for (int i = 0; i < NMON; i++) begin
      ext_word[2*i]   = hd_det[i];
      ext_word[2*i+1] = hd_rise[i];
    end
  end
  assign evt_rise = evt_pending & hd_rise[evt_num];

  always_comb begin
    rd_data = '0;
    if (evt_pending) begin
      case (phase)
        3'd0: rd_data = ext_word;
        3'd1: rd_data = q_ns[rptr][15:0];
        3'd2: rd_data = {2'b00, q_ns[rptr][29:16]};
        3'd3: rd_data = q_sec[rptr][15:0];
        3'd4: rd_data = q_sec[rptr][31:16];
        default: rd_data = '0;
      endcase
    end
  end

  assert_fifo_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULLC);
  assert_head_nonempty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pending |-> (hd_det != '0));
  assert_idx_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_idx <= 3'd4);
  assert_empty_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !evt_pending) |=> (rd_idx == 3'd0));
  assert_missed_sat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_missed == 3'd7 && !pop_w) |=> (evt_missed == 3'd7));
  assert_missed_grow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pop_w |=> (evt_missed >= $past(evt_missed)));
endmodule

// File: tb/sim_evt_stamp_unit.sv
module sim_evt_stamp_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [11:0] pins = '0;
  logic [31:0] sec_base = 32'hA5C3_1E07;
  logic [29:0] ns_base  = 30'h3FFE_0000;
  logic [31:0] tcnt = '0;
  logic [29:0] now_ns;
  logic sel_wr = 0, mode_wr = 0, mode_rise = 0, mode_fall = 0, mode_single = 0, rd_strobe = 0;
  logic [2:0] sel_mon = '0;
  logic [3:0] sel_pin = '0;
  logic evt_pending, evt_multi, evt_rise;
  logic [2:0] evt_num, evt_missed;
  logic [15:0] rd_data;
  int nchk = 0, nfail = 0;
  bit finished = 0;

  always #2 clk = ~clk;
  always @(negedge clk) tcnt <= tcnt + 1;
  assign now_ns = ns_base + tcnt[29:0];

  evt_stamp_unit u0 (
    .clk(clk), .rst_n(rst_n), .pins_in(pins), .now_sec(sec_base), .now_ns(now_ns),
    .sel_wr(sel_wr), .sel_mon(sel_mon), .sel_pin(sel_pin),
    .mode_wr(mode_wr), .mode_rise(mode_rise), .mode_fall(mode_fall), .mode_single(mode_single),
    .evt_pending(evt_pending), .evt_multi(evt_multi), .evt_num(evt_num), .evt_rise(evt_rise),
    .evt_missed(evt_missed), .rd_strobe(rd_strobe), .rd_data(rd_data));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(logic [2:0] m, logic [3:0] p, logic r, logic f, logic s);
    @(negedge clk); sel_wr = 1; sel_mon = m; sel_pin = p;
    @(negedge clk); sel_wr = 0; mode_wr = 1; mode_rise = r; mode_fall = f; mode_single = s;
    @(negedge clk); mode_wr = 0;
    idle(3);
  endtask

  task automatic drive_pin(int k, logic v, output logic [31:0] t);
    @(negedge clk); #1;
    t = tcnt;
    pins[k-1] = v;
  endtask

  task automatic rd_word(output logic [15:0] d);
    @(negedge clk); #1;
    d = rd_data;
    rd_strobe = 1;
    @(negedge clk);
    rd_strobe = 0;
  endtask

  task automatic read_record(string req, logic multi, logic [15:0] ext, logic [31:0] t);
    logic [15:0] d;
    logic [29:0] ns;
    ns = ns_base + t[29:0] + 30'd2;
    @(negedge clk); #1;
    chk({req, " multi flag"}, 32'(evt_multi), 32'(multi));
    if (multi) begin
      rd_word(d); chk({req, " extended word"}, 32'(d), 32'(ext));
    end
    rd_word(d); chk({req, " ns low"}, 32'(d), 32'(ns[15:0]));
    rd_word(d); chk({req, " ns high"}, 32'(d), {18'd0, ns[29:16]});
    rd_word(d); chk({req, " sec low"}, 32'(d), 32'(sec_base[15:0]));
    rd_word(d); chk({req, " sec high"}, 32'(d), 32'(sec_base[31:16]));
  endtask

  task automatic t_reset;
    #1;
    chk("R1 pending", 32'(evt_pending), 0);
    chk("R1 missed", 32'(evt_missed), 0);
    chk("R1 rd_data", 32'(rd_data), 0);
  endtask

  task automatic t_single_rise;
    logic [31:0] t, tx;
    cfg(3'd2, 4'd3, 1, 0, 0);
    drive_pin(3, 1'b1, t);
    idle(4); #1;
    chk("R5 pending", 32'(evt_pending), 1);
    chk("R5 num", 32'(evt_num), 2);
    chk("R5 rise", 32'(evt_rise), 1);
    read_record("R4 R6 single", 0, 16'h0, t);
    #1 chk("R6 popped", 32'(evt_pending), 0);
    drive_pin(3, 1'b0, tx);
    idle(5); #1;
    chk("R3 fall ignored", 32'(evt_pending), 0);
  endtask

  task automatic t_fall;
    logic [31:0] t, tx;
    cfg(3'd5, 4'd12, 0, 1, 0);
    drive_pin(12, 1'b1, tx);
    idle(5); #1;
    chk("R3 rise ignored", 32'(evt_pending), 0);
    drive_pin(12, 1'b0, t);
    idle(4); #1;
    chk("R5 fall num", 32'(evt_num), 5);
    chk("R5 fall flag", 32'(evt_rise), 0);
    read_record("R3 fall", 0, 16'h0, t);
  endtask

  task automatic t_multi;
    logic [31:0] t;
    cfg(3'd0, 4'd1, 1, 0, 0);
    cfg(3'd7, 4'd1, 1, 1, 0);
    drive_pin(1, 1'b1, t);
    idle(4); #1;
    chk("R7 pending", 32'(evt_pending), 1);
    read_record("R7 shared", 1, 16'hC003, t);
    #1 chk("R7 one record", 32'(evt_pending), 0);
  endtask

  task automatic t_unhooked;
    logic [31:0] tx;
    cfg(3'd4, 4'd0, 1, 1, 0);
    cfg(3'd6, 4'd13, 1, 1, 0);
    drive_pin(5, 1'b1, tx); idle(2);
    drive_pin(5, 1'b0, tx); idle(2);
    drive_pin(4, 1'b1, tx); idle(2);
    drive_pin(4, 1'b0, tx); idle(5); #1;
    chk("R2 unattached", 32'(evt_pending), 0);
  endtask

  task automatic t_single_shot;
    logic [31:0] t, tx;
    cfg(3'd1, 4'd6, 1, 0, 1);
    drive_pin(6, 1'b1, t); idle(2);
    drive_pin(6, 1'b0, tx); idle(2);
    drive_pin(6, 1'b1, tx); idle(2);
    drive_pin(6, 1'b0, tx); idle(4);
    read_record("R10 first", 0, 16'h0, t);
    #1 chk("R10 stopped", 32'(evt_pending), 0);
    cfg(3'd1, 4'd6, 1, 0, 1);
    drive_pin(6, 1'b1, t); idle(4); #1;
    chk("R10 rearmed", 32'(evt_pending), 1);
    read_record("R10 rearm", 0, 16'h0, t);
    drive_pin(6, 1'b0, tx); idle(3);
  endtask

  task automatic t_order;
    logic [31:0] t0, t1, t2;
    cfg(3'd1, 4'd7, 1, 1, 0);
    drive_pin(7, 1'b1, t0); idle(3);
    drive_pin(7, 1'b0, t1); idle(3);
    drive_pin(7, 1'b1, t2); idle(4); #1;
    chk("R8 rise first", 32'(evt_rise), 1);
    read_record("R8 first", 0, 16'h0, t0);
    #1 chk("R8 fall second", 32'(evt_rise), 0);
    read_record("R8 second", 0, 16'h0, t1);
    read_record("R8 third", 0, 16'h0, t2);
    #1 chk("R8 drained", 32'(evt_pending), 0);
  endtask

  task automatic t_overflow;
    logic [31:0] ts [4];
    logic [31:0] tx;
    logic v;
    v = 1'b0;
    for (int i = 0; i < 4; i++) begin
      drive_pin(7, v, ts[i]); v = ~v; idle(1);
    end
    for (int i = 0; i < 3; i++) begin
      drive_pin(7, v, tx); v = ~v; idle(1);
    end
    idle(3); #1;
    chk("R9 missed three", 32'(evt_missed), 3);
    for (int i = 0; i < 6; i++) begin
      drive_pin(7, v, tx); v = ~v; idle(1);
    end
    idle(3); #1;
    chk("R9 saturated", 32'(evt_missed), 7);
    read_record("R9 oldest", 0, 16'h0, ts[0]);
    #1;
    chk("R9 cleared", 32'(evt_missed), 0);
    chk("R9 still pending", 32'(evt_pending), 1);
    for (int i = 1; i < 4; i++) read_record("R8 after overflow", 0, 16'h0, ts[i]);
    #1 chk("R9 drained", 32'(evt_pending), 0);
  endtask

  task automatic t_empty_read;
    logic [15:0] d;
    logic [31:0] t;
    rd_word(d);
    chk("R11 empty data", 32'(d), 0);
    rd_word(d);
    cfg(3'd3, 4'd9, 1, 0, 0);
    drive_pin(9, 1'b1, t); idle(4);
    read_record("R11 starts at first word", 0, 16'h0, t);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1;
    idle(2);
    t_single_rise();
    t_fall();
    t_multi();
    t_unhooked();
    t_single_shot();
    t_order();
    t_overflow();
    t_empty_read();
    idle(4);
    summary();
  end
endmodule